// File: doc/BRIEF.md
# Receive Queue with Sticky Interrupt Causes

This block sits between the receiver front end of a serial peripheral and the software read port. A front end offers each received frame with `push_valid_i`. Software takes frames out in arrival order with `pop_req_i`. The storage is one fixed pool of byte lanes. A width code divides the pool into narrow 8-bit entries, medium 16-bit entries or wide 32-bit entries. A wider entry uses more lanes, so the queue holds fewer entries.

Five events are tracked in a 32-bit cause register. Hardware can only set these bits, and software clears them by writing ones. The events are:
- the fill is above a programmable level;
- the queue holds data;
- the queue is at capacity;
- a frame was dropped because the queue was full;
- a pop was made on an empty queue.

A mask register of the same layout selects which causes drive the single level-sensitive interrupt line. The cause bits are wiped while the block is disabled and on a one-cycle clear pulse given when the chip leaves low power.

Top module: `rxq_fifo_irq`

## Requirements
- R1: The cause register resets to zero. Its bit positions are: 0 fill above level, 2 holds data, 3 at capacity, 5 frame dropped on full, 6 pop on empty. All other bits read zero. Each bit is set on the clock edge that ends a cycle in which its condition holds. Conditions use the queue state held at the start of that cycle.
- R2: Writing a vector with `cause_clr_we_i` high clears every cause bit that has a 1 in the vector. Bits with 0 in the vector keep their value. A bit stays set until it is cleared this way or wiped.
- R3: Bit 0 is set in a cycle where the stored entry count is strictly greater than `trig_level_i`.
- R4: Bit 2 is set in a cycle where at least one entry is stored.
- R5: Width code 0 gives 16 entries of 8 bits. Code 1 gives 8 entries of 16 bits. Codes 2 and 3 give 4 entries of 32 bits. Push data bits above the entry width are ignored, and popped data is zero-extended.
- R6: Bit 3 is set in a cycle where the count equals the current capacity. A frame offered while the queue is full is dropped, even if a pop happens in the same cycle.
- R7: Bit 5 is set by any push attempt while the queue is full.
- R8: Bit 6 is set by any pop attempt while the queue is empty. `pop_valid_o` stays low and `pop_data_o` reads zero on such a pop.
- R9: While `enable_i` is low, all cause bits are forced to zero, the queue is emptied, and pushes and pops are ignored. A high pulse on `lp_exit_clr_i` zeroes the cause bits on that edge only.
- R10: A change of the effective width code empties the queue on the next edge. The push and pop offered in that cycle are discarded.
- R11: When a hardware set and a software clear hit the same cause bit in the same cycle, the bit ends up set.
- R12: `irq_o` is high whenever any cause bit is set whose matching bit in the mask register is also set. The mask register is written with `mask_we_i` and resets to zero.
- R13: Frames pop in arrival order. `pop_data_o` and `pop_valid_o` are valid in the same cycle as `pop_req_i`, and the entry is removed on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Block enable; low empties the queue and wipes causes |
| lp_exit_clr_i | input | 1 | One-cycle pulse that wipes causes after low-power exit |
| width_code_i | input | 2 | Entry width code (0 narrow, 1 medium, 2/3 wide) |
| trig_level_i | input | 5 | Fill level that the count must exceed to set bit 0 |
| push_valid_i | input | 1 | Front end offers a frame this cycle |
| push_data_i | input | 32 | Offered frame, low bits used for narrow entries |
| pop_req_i | input | 1 | Software reads one entry this cycle |
| pop_data_o | output | 32 | Entry at the head, zero-extended |
| pop_valid_o | output | 1 | The pop this cycle returned an entry |
| cause_clr_we_i | input | 1 | Apply the write-one-to-clear vector |
| cause_clr_i | input | 32 | Write-one-to-clear vector |
| mask_we_i | input | 1 | Load the mask register |
| mask_wdata_i | input | 32 | New mask value |
| cause_o | output | 32 | Sticky cause register |
| irq_o | output | 1 | OR of masked causes |

## Verification
The hardware set and the software write-one-clear of the same cause bit can fall in the same cycle. The bench provokes this by filling the wide layout to capacity. It then issues an all-ones clear in the same cycle as one more push. The at-capacity and holds-data bits must survive the clear, and the drop bit must appear. The bench also overlaps the low-power clear pulse with a queue that still holds data. The bits must read zero right after the pulse and come back one edge later.

// File: rtl/rxq_pkg.sv
// Package: shared constants, types and helpers for the receive queue.
// Assumes a 32-bit cause register with five implemented bits.
package rxq_pkg;

    localparam int CAUSE_W  = 32;
    localparam int C_TRIG   = 0;
    localparam int C_NEMPTY = 2;
    localparam int C_FULL   = 3;
    localparam int C_OVF    = 5;
    localparam int C_UNF    = 6;

    // Implemented cause bits; all others read zero.
    localparam logic [CAUSE_W-1:0] CAUSE_IMPL = 32'h0000_006D;

    typedef enum logic [1:0] {
        EW_NARROW = 2'd0,
        EW_MEDIUM = 2'd1,
        EW_WIDE   = 2'd2,
        EW_RSVD   = 2'd3
    } entry_width_e;

    typedef struct packed {
        logic trig;
        logic nempty;
        logic full;
        logic ovf;
        logic unf;
    } cause_evt_t;

    // Clamp a width code to the widest layout the lane count allows.
    function automatic logic [1:0] eff_code(input logic [1:0] code, input logic [1:0] cmax);
        return (code > cmax) ? cmax : code;
    endfunction

    // Place the event flags at their register positions.
    function automatic logic [CAUSE_W-1:0] pack_causes(input cause_evt_t e);
        logic [CAUSE_W-1:0] v;
        v           = '0;
        v[C_TRIG]   = e.trig;
        v[C_NEMPTY] = e.nempty;
        v[C_FULL]   = e.full;
        v[C_OVF]    = e.ovf;
        v[C_UNF]    = e.unf;
        return v;
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
// Module: rxq_ctrl
// Keeps the pointers and the entry count of the receive queue, and holds
// the width code in force. Capacity is the base count shifted right by
// that code. A change of code or a low enable empties the queue and
// discards the push and pop of that cycle.
// Assumes: BASE_ENTRIES is a power of two and at least 1 << CODE_MAX.
module rxq_ctrl #(
    parameter int BASE_ENTRIES = 16,
    parameter int CODE_MAX     = 2,
    localparam int PTR_W       = $clog2(BASE_ENTRIES),
    localparam int CNT_W       = $clog2(BASE_ENTRIES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       code_in,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [1:0]       code_act,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             full,
    output logic             empty,
    output logic             flush
);
    import rxq_pkg::*;

    logic [1:0]       code_eff;
    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] last_idx;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;

    // Derive capacity, flags and the accepted operations of this cycle.
    always_comb begin
        code_eff = eff_code(code_in, 2'(CODE_MAX));
        flush    = !enable || (code_eff != code_act);
        cap      = CNT_W'(BASE_ENTRIES) >> code_act;
        last_idx = PTR_W'(cap - CNT_W'(1));
        full     = (count == cap);
        empty    = (count == '0);
        push_ok  = push_req && !flush && !full;
        pop_ok   = pop_req && !flush && !empty;
        wr_nxt   = (wr_ptr == last_idx) ? '0 : wr_ptr + PTR_W'(1);
        rd_nxt   = (rd_ptr == last_idx) ? '0 : rd_ptr + PTR_W'(1);
    end

    // Advance the pointers and the count, or empty the queue on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_act <= EW_NARROW;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
        end else begin
            code_act <= code_eff;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (push_ok) wr_ptr <= wr_nxt;
                if (pop_ok)  rd_ptr <= rd_nxt;
                case ({push_ok, pop_ok})
                    2'b10:   count <= count + CNT_W'(1);
                    2'b01:   count <= count - CNT_W'(1);
                    default: count <= count;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxq_lane_store.sv
// Module: rxq_lane_store
// The storage pool: BASE_ENTRIES byte-wide lanes. An entry at index p in
// layout c takes lanes (p << c) to (p << c) + (1 << c) - 1. Lanes that an
// entry does not use read back as zero.
// Assumes the pointers stay below the capacity of the layout in force.
// The storage has no reset; nothing reads it before it is written.
module rxq_lane_store #(
    parameter int BASE_ENTRIES = 16,
    parameter int LANE_W       = 8,
    parameter int MAX_LANES    = 4,
    localparam int PTR_W       = $clog2(BASE_ENTRIES),
    localparam int DATA_W      = LANE_W * MAX_LANES
) (
    input  logic              clk,
    input  logic [1:0]        code,
    input  logic              we,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rdata
);
    logic [LANE_W-1:0] mem [BASE_ENTRIES];
    logic [MAX_LANES-1:0] lane_on;
    logic [PTR_W-1:0]     wr_addr [MAX_LANES];
    logic [PTR_W-1:0]     rd_addr [MAX_LANES];

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        // Per-lane enable and the lane addresses of the write and read entries.
        always_comb begin
            lane_on[l] = (32'(l) < (32'd1 << code));
            wr_addr[l] = (wr_ptr << code) + PTR_W'(l);
            rd_addr[l] = (rd_ptr << code) + PTR_W'(l);
            rdata[l*LANE_W +: LANE_W] = lane_on[l] ? mem[rd_addr[l]] : '0;
        end
    end

    // Write the used lanes of an accepted frame.
    always_ff @(posedge clk) begin
        for (int l = 0; l < MAX_LANES; l++) begin
            if (we && lane_on[l]) mem[wr_addr[l]] <= wdata[l*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/rxq_cause_reg.sv
// Module: rxq_cause_reg
// Holds the sticky cause bits and the interrupt mask, and forms the
// interrupt line. A hardware set beats a write-one clear in the same
// cycle. A wipe zeroes every cause bit. Unimplemented bits are held at zero.
module rxq_cause_reg #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic [CW-1:0] set_vec,
    input  logic          clr_we,
    input  logic [CW-1:0] clr_vec,
    input  logic          mask_we,
    input  logic [CW-1:0] mask_vec,
    output logic [CW-1:0] cause_q,
    output logic [CW-1:0] mask_q,
    output logic          irq
);
    import rxq_pkg::*;

    logic [CW-1:0] clr_eff;

    // Gate the clear vector with its write strobe.
    always_comb clr_eff = clr_we ? clr_vec : '0;

    // Sticky update: clear first, then OR in the new events; wipe wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    cause_q <= '0;
        else if (wipe) cause_q <= '0;
        else           cause_q <= ((cause_q & ~clr_eff) | set_vec) & CW'(CAUSE_IMPL);
    end

    // Load the mask on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_vec & CW'(CAUSE_IMPL);
    end

    // Level interrupt from the masked causes.
    always_comb irq = |(cause_q & mask_q);

endmodule

// File: rtl/rxq_fifo_irq.sv
// Module: rxq_fifo_irq (top)
// Receive queue with width-selectable entries and sticky interrupt
// causes. Ties together the queue control, the lane storage and the
// cause register. Assumes a single clock and a synchronous active-low reset.
module rxq_fifo_irq #(
    parameter int BASE_ENTRIES = 16,
    parameter int LANE_W       = 8,
    parameter int MAX_LANES    = 4,
    localparam int DATA_W      = LANE_W * MAX_LANES,
    localparam int CNT_W       = $clog2(BASE_ENTRIES) + 1,
    localparam int PTR_W       = $clog2(BASE_ENTRIES),
    localparam int CODE_MAX    = $clog2(MAX_LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              lp_exit_clr_i,
    input  logic [1:0]        width_code_i,
    input  logic [CNT_W-1:0]  trig_level_i,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_req_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              pop_valid_o,
    input  logic              cause_clr_we_i,
    input  logic [31:0]       cause_clr_i,
    input  logic              mask_we_i,
    input  logic [31:0]       mask_wdata_i,
    output logic [31:0]       cause_o,
    output logic              irq_o
);
    import rxq_pkg::*;

    logic [1:0]        code_act;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count_w;
    logic              push_ok;
    logic              pop_ok;
    logic              full_w;
    logic              empty_w;
    logic              flush_w;
    logic [DATA_W-1:0] head_data;
    cause_evt_t        evt;
    logic [31:0]       set_vec;
    logic [31:0]       mask_q;

    rxq_ctrl #(
        .BASE_ENTRIES(BASE_ENTRIES),
        .CODE_MAX    (CODE_MAX)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable_i),
        .code_in (width_code_i),
        .push_req(push_valid_i),
        .pop_req (pop_req_i),
        .code_act(code_act),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count_w),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .full    (full_w),
        .empty   (empty_w),
        .flush   (flush_w)
    );

    rxq_lane_store #(
        .BASE_ENTRIES(BASE_ENTRIES),
        .LANE_W      (LANE_W),
        .MAX_LANES   (MAX_LANES)
    ) u_store (
        .clk   (clk),
        .code  (code_act),
        .we    (push_ok),
        .wr_ptr(wr_ptr),
        .wdata (push_data_i),
        .rd_ptr(rd_ptr),
        .rdata (head_data)
    );

    // Read port: head entry only when the pop is accepted.
    always_comb begin
        pop_valid_o = pop_ok;
        pop_data_o  = pop_ok ? head_data : '0;
    end

    // Cause conditions from the state held at the start of the cycle.
    always_comb begin
        evt.trig   = count_w > trig_level_i;
        evt.nempty = !empty_w;
        evt.full   = full_w;
        evt.ovf    = push_valid_i && !flush_w && full_w;
        evt.unf    = pop_req_i && !flush_w && empty_w;
        set_vec    = pack_causes(evt);
    end

    rxq_cause_reg #(
        .CW(32)
    ) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (!enable_i || lp_exit_clr_i),
        .set_vec (set_vec),
        .clr_we  (cause_clr_we_i),
        .clr_vec (cause_clr_i),
        .mask_we (mask_we_i),
        .mask_vec(mask_wdata_i),
        .cause_q (cause_o),
        .mask_q  (mask_q),
        .irq     (irq_o)
    );

endmodule

// File: rtl/rxq_fifo_irq_chk.sv
// Module: rxq_fifo_irq_chk
// Checker bound into rxq_fifo_irq. Watches the ports together with the
// queue flags that the control block drives.
module rxq_fifo_irq_chk #(
    parameter int BASE_ENTRIES = 16,
    localparam int CNT_W       = $clog2(BASE_ENTRIES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             lp_exit_clr_i,
    input logic             push_valid_i,
    input logic             pop_req_i,
    input logic             pop_valid_o,
    input logic             cause_clr_we_i,
    input logic [31:0]      cause_clr_i,
    input logic [31:0]      cause_o,
    input logic             full_w,
    input logic             empty_w,
    input logic             flush_w,
    input logic [CNT_W-1:0] count_w
);
    import rxq_pkg::*;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o & ~CAUSE_IMPL) == 32'h0);                                  // R1
    AST_DISABLE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i || lp_exit_clr_i) |=> cause_o == 32'h0);                 // R9
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        count_w <= CNT_W'(BASE_ENTRIES));                                   // R6
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !lp_exit_clr_i && !flush_w && push_valid_i && full_w)
        |=> cause_o[C_OVF]);                                                // R7
    AST_EMPTY_POP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !lp_exit_clr_i && !flush_w && pop_req_i && empty_w)
        |=> cause_o[C_UNF]);                                                // R8
    AST_EMPTY_POP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req_i && empty_w) |-> !pop_valid_o);                           // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |=> count_w == '0);                                         // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !lp_exit_clr_i && full_w && cause_clr_we_i && cause_clr_i[C_FULL])
        |=> cause_o[C_FULL]);                                               // R11

endmodule

bind rxq_fifo_irq rxq_fifo_irq_chk #(.BASE_ENTRIES(BASE_ENTRIES)) u_chk (.*);

// File: tb/tb_rxq_fifo_irq.sv
`timescale 1ns/1ps
// Directed bench for rxq_fifo_irq. Each task drives one scenario and checks it.
module tb_rxq_fifo_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b1;
    logic        lp_exit_clr_i = 1'b0;
    logic [1:0]  width_code_i = 2'd0;
    logic [4:0]  trig_level_i = 5'd16;
    logic        push_valid_i = 1'b0;
    logic [31:0] push_data_i = '0;
    logic        pop_req_i = 1'b0;
    logic [31:0] pop_data_o;
    logic        pop_valid_o;
    logic        cause_clr_we_i = 1'b0;
    logic [31:0] cause_clr_i = '0;
    logic        mask_we_i = 1'b0;
    logic [31:0] mask_wdata_i = '0;
    logic [31:0] cause_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rxq_fifo_irq dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_one(input logic [31:0] d);
        push_valid_i = 1'b1;
        push_data_i  = d;
        step();
        push_valid_i = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic v, input logic [31:0] d);
        pop_req_i = 1'b1;
        #1;
        check({req, " valid"}, 32'(pop_valid_o), 32'(v));
        check({req, " data"}, pop_data_o, d);
        step();
        pop_req_i = 1'b0;
    endtask

    task automatic clear_all();
        cause_clr_we_i = 1'b1;
        cause_clr_i    = 32'hFFFF_FFFF;
        step();
        cause_clr_we_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset cause", cause_o, 32'h0);
        check("R12 reset irq", 32'(irq_o), 32'h0);
        check("R13 idle valid", 32'(pop_valid_o), 32'h0);
    endtask

    task automatic t_order();
        push_one(32'h1A2B_3C11);
        push_one(32'h1A2B_3C22);
        push_one(32'h1A2B_3C33);
        step();
        check("R4 holds data", cause_o, 32'h0000_0004);
        pop_expect("R13 first", 1'b1, 32'h11);
        pop_expect("R5 narrow zero-ext", 1'b1, 32'h22);
        pop_expect("R13 third", 1'b1, 32'h33);
    endtask

    task automatic t_w1c();
        step();
        check("R2 sticky after drain", cause_o, 32'h0000_0004);
        cause_clr_we_i = 1'b1; cause_clr_i = 32'h0; step(); cause_clr_we_i = 1'b0;
        check("R2 zero write no effect", cause_o, 32'h0000_0004);
        cause_clr_we_i = 1'b1; cause_clr_i = 32'h0000_0004; step(); cause_clr_we_i = 1'b0;
        check("R2 one clears", cause_o, 32'h0);
    endtask

    task automatic t_underflow();
        pop_expect("R8 empty pop", 1'b0, 32'h0);
        check("R8 cause set", cause_o, 32'h0000_0040);
        clear_all();
    endtask

    task automatic t_trigger();
        trig_level_i = 5'd2;
        push_one(32'hA1); push_one(32'hA2);
        step();
        check("R3 count equal level", 32'(cause_o[0]), 32'h0);
        push_one(32'hA3);
        step();
        check("R3 count above level", 32'(cause_o[0]), 32'h1);
        trig_level_i = 5'd16;
        for (int i = 0; i < 3; i++) pop_expect("R3 drain", 1'b1, 32'(8'hA1 + 8'(i)));
        clear_all();
    endtask

    task automatic t_capacity(input logic [1:0] code);
        int cap;
        logic [31:0] msk;
        cap = (code == 2'd0) ? 16 : (code == 2'd1) ? 8 : 4;
        msk = (code == 2'd0) ? 32'hFF : (code == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        width_code_i = code;
        step();
        clear_all();
        for (int i = 0; i < cap; i++) push_one({8'(8'h40 + i), 8'(8'h30 + i), 8'(8'h20 + i), 8'(8'h10 + i)});
        step();
        check("R6 full set", 32'(cause_o[3]), 32'h1);
        check("R7 no drop yet", 32'(cause_o[5]), 32'h0);
        push_one(32'hDEAD_BEEF);
        step();
        check("R7 drop flagged", 32'(cause_o[5]), 32'h1);
        for (int i = 0; i < cap; i++)
            pop_expect("R5 entry", 1'b1, {8'(8'h40 + i), 8'(8'h30 + i), 8'(8'h20 + i), 8'(8'h10 + i)} & msk);
        pop_expect("R6 dropped frame absent", 1'b0, 32'h0);
        clear_all();
    endtask

    task automatic t_set_wins();
        width_code_i = 2'd2;
        step();
        clear_all();
        for (int i = 0; i < 4; i++) push_one(32'h5500_0000 + 32'(i));
        step();
        cause_clr_we_i = 1'b1; cause_clr_i = 32'hFFFF_FFFF;
        push_valid_i = 1'b1; push_data_i = 32'h1234_5678;
        step();
        cause_clr_we_i = 1'b0; push_valid_i = 1'b0;
        check("R11 set beats clear", cause_o, 32'h0000_002C);
        for (int i = 0; i < 4; i++) pop_expect("R11 contents", 1'b1, 32'h5500_0000 + 32'(i));
        clear_all();
    endtask

    task automatic t_flush();
        width_code_i = 2'd0;
        step();
        push_one(32'h77); push_one(32'h78);
        width_code_i = 2'd1;
        step();
        pop_expect("R10 flushed on code change", 1'b0, 32'h0);
        width_code_i = 2'd0;
        step();
        clear_all();
    endtask

    task automatic t_disable();
        push_one(32'h61); push_one(32'h62);
        step();
        check("R9 before disable", cause_o, 32'h0000_0004);
        enable_i = 1'b0;
        step();
        check("R9 disabled wipe", cause_o, 32'h0);
        push_one(32'h63);
        step();
        check("R9 disabled stays zero", cause_o, 32'h0);
        enable_i = 1'b1;
        step();
        pop_expect("R9 emptied while disabled", 1'b0, 32'h0);
        clear_all();
        push_one(32'h64);
        step();
        lp_exit_clr_i = 1'b1;
        step();
        lp_exit_clr_i = 1'b0;
        check("R9 pulse wipe", cause_o, 32'h0);
        step();
        check("R9 pulse only", cause_o, 32'h0000_0004);
    endtask

    task automatic t_mask();
        mask_we_i = 1'b1; mask_wdata_i = 32'h0000_0004; step(); mask_we_i = 1'b0;
        check("R12 irq masked in", 32'(irq_o), 32'h1);
        mask_we_i = 1'b1; mask_wdata_i = 32'h0000_0020; step(); mask_we_i = 1'b0;
        check("R12 irq masked out", 32'(irq_o), 32'h0);
        pop_expect("R12 drain", 1'b1, 32'h64);
        clear_all();
        mask_we_i = 1'b1; mask_wdata_i = 32'hFFFF_FFFF; step(); mask_we_i = 1'b0;
        check("R12 no cause no irq", 32'(irq_o), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_order();
        t_w1c();
        t_underflow();
        t_trigger();
        t_capacity(2'd0);
        t_capacity(2'd1);
        t_capacity(2'd2);
        t_capacity(2'd3);
        t_set_wins();
        t_flush();
        t_disable();
        t_mask();
        finish_run();
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule